// File: doc/BRIEF.md
# Interrupt Source Masking and Routing

This block gathers a vector of level-sensitive hardware interrupt lines and a register of software-raised requests. It merges them into one raw pending vector and sends each source down one of two paths. A source whose routing bit is set feeds the fast interrupt output. A source whose routing bit is clear feeds the normal path only if its enable bit is set. The normal path leaves the block as a masked pending vector, which a separate priority unit consumes. The fast path is reduced to a single output line.

Software reaches the block through a simple word-addressed register port with `req`, `we`, `addr`, `wdata` and a registered read response. The enable mask and the software request register each have two addresses: one where a written one sets the bit and one where a written one clears it. A fixed block of eight identification bytes sits at the top of the window, one byte per word.

Top module: `irq_route_ctrl`

## Requirements
- R1: The raw pending vector is the bitwise OR of the sampled hardware lines and the software request register, and reads at word 2.
- R2: `irq_pend` equals raw AND enable AND NOT route-select, and the same value reads at word 0.
- R3: Fast status equals raw AND route-select, whatever the enable state, and reads at word 1. `fiq_out` is high exactly when fast status is nonzero.
- R4: A write to word 4 ORs the data into the enable mask. A write to word 5 clears every enable bit written as one. The mask reads at word 4.
- R5: A write to word 6 ORs the data into the software request register. A write to word 7 clears every bit written as one. The register reads at word 6.
- R6: Word 3 holds the route-select mask. A write replaces the whole mask and a read returns it.
- R7: Word 8 stores only data bit 0 as a protection flag. A read returns that flag in bit 0 and zero in the other bits.
- R8: Writes to word 0 and to unmapped words change no state. Reads of words 5, 7 and of unmapped words return zero.
- R9: Reads of words 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) return the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order, in bits 7:0.
- R10: After reset, enable, route-select, software request and protection are all zero, `irq_pend` is zero and `fiq_out` is low.
- R11: A read request (`bus_req` high, `bus_we` low) gives `bus_rvalid` high for exactly the next cycle, with the data in `bus_rdata`. At all other times `bus_rvalid` is low and `bus_rdata` is zero.
- R12: Hardware lines are sampled on each clock edge, so a change first appears on `irq_pend` and `fiq_out` after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_irq | input | NSRC | Level-sensitive hardware interrupt lines |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| irq_pend | output | NSRC | Masked normal-path pending vector |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
A corrupted enable, select or software register shows up one edge after the write that set it. It appears both on `irq_pend`/`fiq_out` and in the readback of the register, so every write is followed by a port comparison and a register read. Wrong set/clear semantics show up only when existing bits survive a later write, so the sequences layer set and clear writes on a nonzero mask. The bench also checks the sampling latency of the hardware lines halfway through the cycle in which they change, and checks that unenabled sources still reach the fast path.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned W_IRQ_STAT = 0;
  localparam int unsigned W_FIQ_STAT = 1;
  localparam int unsigned W_RAW      = 2;
  localparam int unsigned W_ROUTE    = 3;
  localparam int unsigned W_EN_SET   = 4;
  localparam int unsigned W_EN_CLR   = 5;
  localparam int unsigned W_SW_SET   = 6;
  localparam int unsigned W_SW_CLR   = 7;
  localparam int unsigned W_PROT     = 8;
  localparam int unsigned ID_WORDS   = 8;

  typedef struct packed {
    logic route_wr;
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic prot_wr;
  } wr_strobe_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h90;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wr_strobe_t      wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] sw_q,
  output logic            prot_q
);

  logic [NSRC-1:0] en_d, route_d, sw_d;
  logic            prot_d;
  logic            en_ce, route_ce, sw_ce, prot_ce;

  always_comb begin
    en_ce    = wr.en_set | wr.en_clr;
    route_ce = wr.route_wr;
    sw_ce    = wr.sw_set | wr.sw_clr;
    prot_ce  = wr.prot_wr;
    en_d     = en_q;
    sw_d     = sw_q;
    if (wr.en_set) en_d = en_q | wdata;
    if (wr.en_clr) en_d = en_q & ~wdata;
    if (wr.sw_set) sw_d = sw_q | wdata;
    if (wr.sw_clr) sw_d = sw_q & ~wdata;
    route_d = wdata;
    prot_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      sw_q    <= '0;
      prot_q  <= 1'b0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (route_ce) route_q <= route_d;
      if (sw_ce)    sw_q    <= sw_d;
      if (prot_ce)  prot_q  <= prot_d;
    end
  end

endmodule

// File: rtl/irq_route_logic.sv
module irq_route_logic #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_irq,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] route_q,
  input  logic [NSRC-1:0] sw_q,
  output logic [NSRC-1:0] hw_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat,
  output logic            fiq_any
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= '0;
    else        hw_q <= hw_irq;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      raw[i]      = hw_q[i] | sw_q[i];
      irq_stat[i] = raw[i] & en_q[i] & ~route_q[i];
      fiq_stat[i] = raw[i] & route_q[i];
    end
  end

  assign fiq_any = |fiq_stat;

endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 10,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] irq_stat,
  input  logic [NSRC-1:0] fiq_stat,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] route_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] sw_q,
  input  logic            prot_q,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);

  localparam int unsigned IDW = $clog2(ID_WORDS);

  logic          in_id;
  logic [DW-1:0] mux_d, rdata_d;
  logic          rvalid_d;

  always_comb begin
    in_id = &addr[AW-1:IDW];
    mux_d = '0;
    if (in_id) begin
      mux_d[7:0] = id_byte(addr[IDW-1:0]);
    end else begin
      case (addr)
        AW'(W_IRQ_STAT): mux_d = DW'(irq_stat);
        AW'(W_FIQ_STAT): mux_d = DW'(fiq_stat);
        AW'(W_RAW):      mux_d = DW'(raw);
        AW'(W_ROUTE):    mux_d = DW'(route_q);
        AW'(W_EN_SET):   mux_d = DW'(en_q);
        AW'(W_SW_SET):   mux_d = DW'(sw_q);
        AW'(W_PROT):     mux_d = DW'(prot_q);
        default:         mux_d = '0;
      endcase
    end
    rvalid_d = rd_req;
    rdata_d  = rd_req ? mux_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      rvalid <= rvalid_d;
    end
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 10,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_irq,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  output logic [NSRC-1:0] irq_pend,
  output logic            fiq_out
);

  logic            rst_meta, rst_sync_n;
  logic            wr_any, rd_req;
  wr_strobe_t      wr;
  logic [NSRC-1:0] en_q, route_q, sw_q, hw_q, raw, irq_stat, fiq_stat;
  logic            prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    wr_any      = bus_req & bus_we;
    rd_req      = bus_req & ~bus_we;
    wr.route_wr = wr_any && (bus_addr == AW'(W_ROUTE));
    wr.en_set   = wr_any && (bus_addr == AW'(W_EN_SET));
    wr.en_clr   = wr_any && (bus_addr == AW'(W_EN_CLR));
    wr.sw_set   = wr_any && (bus_addr == AW'(W_SW_SET));
    wr.sw_clr   = wr_any && (bus_addr == AW'(W_SW_CLR));
    wr.prot_wr  = wr_any && (bus_addr == AW'(W_PROT));
  end

  irq_src_regs #(.NSRC(NSRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (wr),
    .wdata   (bus_wdata[NSRC-1:0]),
    .en_q    (en_q),
    .route_q (route_q),
    .sw_q    (sw_q),
    .prot_q  (prot_q)
  );

  irq_route_logic #(.NSRC(NSRC)) u_route (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hw_irq   (hw_irq),
    .en_q     (en_q),
    .route_q  (route_q),
    .sw_q     (sw_q),
    .hw_q     (hw_q),
    .raw      (raw),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat),
    .fiq_any  (fiq_out)
  );

  irq_reg_read #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_read (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .addr     (bus_addr),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat),
    .raw      (raw),
    .route_q  (route_q),
    .en_q     (en_q),
    .sw_q     (sw_q),
    .prot_q   (prot_q),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  assign irq_pend = irq_stat;

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 10,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] hw_irq,
  input logic            bus_req,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_rvalid,
  input logic [NSRC-1:0] irq_pend,
  input logic            fiq_out,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] route_q,
  input logic [NSRC-1:0] sw_q,
  input logic [NSRC-1:0] hw_q
);

  // R2: no pending bit without enable, none for a fast-routed source
  a_r2_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & ~en_q) == '0) && ((irq_pend & route_q) == '0));

  // R3: fast output implies an active fast-routed source
  a_r3_fiq_source: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> ((route_q & (hw_q | sw_q)) != '0));

  // R4: set-write leaves all written bits set
  a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == AW'(4)) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  // R5: clear-write leaves all written bits clear
  a_r5_sw_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == AW'(7)) |=>
      ((sw_q & $past(bus_wdata[NSRC-1:0])) == '0));

  // R8: a write to word 0 changes no state
  a_r8_word0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == '0) |=>
      ($stable(en_q) && $stable(route_q) && $stable(sw_q)));

  // R11: read request gives a response next cycle, nothing else does
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
  a_r11_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R12: lines are captured on each edge
  a_r12_sample: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hw_q == $past(hw_irq)));

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .hw_irq     (hw_irq),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .irq_pend   (irq_pend),
  .fiq_out    (fiq_out),
  .en_q       (en_q),
  .route_q    (route_q),
  .sw_q       (sw_q),
  .hw_q       (hw_q)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

  localparam int NSRC = 32;
  localparam int AW   = 10;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] hw_irq = '0;
  logic            bus_req = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            bus_rvalid;
  logic [NSRC-1:0] irq_pend;
  logic            fiq_out;

  always #10 clk = ~clk;

  irq_route_ctrl #(.NSRC(NSRC), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_pend(irq_pend), .fiq_out(fiq_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_en = '0, m_route = '0, m_sw = '0, m_hw = '0;
  logic        m_prot = 1'b0;
  logic [7:0]  id_tbl [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] m_raw();
    return m_hw | m_sw;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    if (a >= 10'h3F8) return {24'h0, id_tbl[a - 10'h3F8]};
    case (a)
      10'd0:   return m_raw() & m_en & ~m_route;
      10'd1:   return m_raw() & m_route;
      10'd2:   return m_raw();
      10'd3:   return m_route;
      10'd4:   return m_en;
      10'd6:   return m_sw;
      10'd8:   return {31'h0, m_prot};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    case (a)
      10'd3: m_route = d;
      10'd4: m_en = m_en | d;
      10'd5: m_en = m_en & ~d;
      10'd6: m_sw = m_sw | d;
      10'd7: m_sw = m_sw & ~d;
      10'd8: m_prot = d[0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic check_out(input string tag);
    @(negedge clk);
    check({tag, " irq_pend"}, irq_pend, m_raw() & m_en & ~m_route);
    check({tag, " fiq_out"}, {31'h0, fiq_out}, {31'h0, |(m_raw() & m_route)});
    check("R11 idle rvalid/rdata", bus_rdata | {31'h0, bus_rvalid}, 32'h0);
  endtask

  task automatic set_hw(input logic [31:0] v);
    logic [31:0] old_irq;
    @(negedge clk);
    old_irq = m_raw() & m_en & ~m_route;
    hw_irq = v;
    #1 check("R12 before edge", irq_pend, old_irq);
    m_hw = v;
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R11: unexpected response actual %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check_out("R10 reset");
    for (int w = 0; w <= 8; w++) bus_read(AW'(w), "R10 reset read");

    bus_write(10'd4, 32'h0000_00FF);
    set_hw(32'h0000_0F0F);
    check_out("R2 enabled low byte");
    bus_read(10'd0, "R2 irq status");
    bus_read(10'd2, "R1 raw hw only");

    bus_write(10'd4, 32'hF000_0000);
    bus_read(10'd4, "R4 enable OR");
    bus_write(10'd5, 32'h0000_000F);
    bus_read(10'd4, "R4 enable clear");
    check_out("R4 outputs after clear");

    bus_write(10'd6, 32'h3000_0000);
    bus_read(10'd6, "R5 soft set");
    bus_read(10'd2, "R1 raw hw|soft");
    check_out("R5 soft pending");
    bus_write(10'd7, 32'h1000_0000);
    bus_read(10'd6, "R5 soft clear");
    check_out("R5 outputs after clear");

    bus_write(10'd3, 32'h2000_0100);
    check_out("R3 fast path unenabled bit");
    bus_read(10'd1, "R3 fiq status");
    bus_read(10'd3, "R6 route read");
    bus_write(10'd3, 32'h0000_0000);
    bus_read(10'd3, "R6 route replace");
    check_out("R3 fiq low");

    set_hw(32'h0000_0000);
    check_out("R12 hw removed");
    set_hw(32'hA5A5_0081);
    check_out("R12 new pattern");

    bus_write(10'd0, 32'hFFFF_FFFF);
    bus_write(10'h010, 32'hFFFF_FFFF);
    bus_read(10'd4, "R8 enable untouched");
    bus_read(10'd6, "R8 soft untouched");
    bus_read(10'd3, "R8 route untouched");
    bus_read(10'h010, "R8 unmapped read");
    bus_read(10'd5, "R8 word5 read");
    bus_read(10'd7, "R8 word7 read");
    check_out("R8 outputs unchanged");

    bus_write(10'd8, 32'hFFFF_FFFF);
    bus_read(10'd8, "R7 prot set");
    bus_write(10'd8, 32'h0000_0002);
    bus_read(10'd8, "R7 prot bit0 only");

    for (int i = 0; i < 8; i++) bus_read(AW'(10'h3F8 + i), "R9 id byte");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R11: missing responses actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule